// File: doc/BRIEF.md
# Dual-Bus Manchester Word Decoder

This block watches two independent serial buses. Each bus arrives as a pair of comparator outputs. On each clock the pair reads as one of three line states: a high level (positive output only), a low level (negative output only), or idle (neither output). The line is oversampled at a fixed number of clock samples per bit cell. For each bus, a decoder finds the three-bit-long synchronisation pattern and recovers sixteen data bits and one parity bit in bi-phase (Manchester II) code. It then validates the whole word before anything is passed on.

A word that passes every check is copied into that bus's receive register. It also raises the bus's receive-valid flag and records the polarity of its sync pattern. A word that fails any check leaves the receive register alone and sets a sticky error flag instead. A combined error output reports a flagged error on either bus. A 16-bit status word shows the valid and error flags at fixed positions. The two decoders share nothing except the clock and the master reset.

Top module: `mwd_dual_rx`

## Requirements
- R1: A well-formed word does the following. The 16 data bits, MSB first, are loaded into that bus's receive register, and the bus's receive-valid flag goes high. The sync flag is 1 when the sync pattern starts with 1.5 bit cells of high level (command/status sync) and 0 when it starts with low level (data sync). In each data cell, a 1 is sent as high then low and a 0 as low then high.
- R2: A one-cycle pulse on a bus's read strobe clears that bus's receive-valid flag. It leaves the other bus's flag unchanged.
- R3: A bit cell with no mid-cell transition sets that bus's error flag. Such a word neither raises receive-valid nor changes the receive register.
- R4: Parity is odd over the 16 data bits plus the parity bit. A word with even parity sets the error flag and is not delivered.
- R5: A word where the line goes idle before all 17 bit cells have been received is flagged as an error.
- R6: A word followed directly, with no idle gap, by a further bit cell is flagged as an error.
- R7: The status word carries bus A receive-valid in bit 7, bus A error in bit 10, bus B receive-valid in bit 11 and bus B error in bit 14. All other bits are zero. The combined error output is high whenever either error flag is set.
- R8: An error flag stays set until the error-clear input is pulsed. The pulse clears both flags.
- R9: The two buses are decoded independently, including words that arrive at the same time.
- R10: Master reset clears both receive registers, all flags and the sync flags.
- R11: A first sync half that lasts outside 1.5 cells ± a quarter cell is not taken as a word. It raises neither receive-valid nor error. The two boundary lengths are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OSR samples per bit cell |
| mr | input | 1 | Master reset, active high, asynchronous |
| bus_a_pos | input | 1 | Bus A comparator, positive level |
| bus_a_neg | input | 1 | Bus A comparator, negative level |
| bus_b_pos | input | 1 | Bus B comparator, positive level |
| bus_b_neg | input | 1 | Bus B comparator, negative level |
| rd_a | input | 1 | Bus A read strobe, clears receive-valid |
| rd_b | input | 1 | Bus B read strobe, clears receive-valid |
| err_clr | input | 1 | Clears both error flags |
| rx_word_a | output | 16 | Bus A receive register |
| rx_word_b | output | 16 | Bus B receive register |
| rcv_a | output | 1 | Bus A receive-valid |
| rcv_b | output | 1 | Bus B receive-valid |
| sync_cmd_a | output | 1 | Bus A sync polarity of last valid word |
| sync_cmd_b | output | 1 | Bus B sync polarity of last valid word |
| err_any | output | 1 | Error on either bus |
| status | output | 16 | Packed flag word |

## Verification
The bench removes the mid-cell transition from each of the 17 bit cells in turn. A decoder that skipped a cell, or checked only the data bits, would deliver a corrupted word as valid. It sends words one cell short and one or two cells long, which catches a bit counter that is off by one or a decoder that never checks for the idle gap after the parity bit. It sends sync halves at exactly the accepted boundary lengths and one sample beyond them, which exposes window comparisons with the wrong bound. Simultaneous traffic on both buses, together with per-bus reads, would show any cross-wiring of flags or registers between the two decoders.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_SYNC1,
      ST_SYNC2,
      ST_BITS,
      ST_TAIL
   } dec_state_t;

   localparam int WORD_BITS  = 16;
   localparam int FRAME_BITS = WORD_BITS + 1;
   localparam int STAT_RCV_A = 7;
   localparam int STAT_ERR_A = 10;
   localparam int STAT_RCV_B = 11;
   localparam int STAT_ERR_B = 14;
endpackage

// File: rtl/mwd_line_sync.sv
module mwd_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic mr,
   input  logic line_pos,
   input  logic line_neg,
   output logic samp_pos,
   output logic samp_neg
);
   logic [STAGES-1:0] pos_q;
   logic [STAGES-1:0] neg_q;

   always_ff @(posedge clk or posedge mr) begin
      if (mr) begin
         pos_q <= '0;
         neg_q <= '0;
      end else begin
         pos_q <= {pos_q[STAGES-2:0], line_pos};
         neg_q <= {neg_q[STAGES-2:0], line_neg};
      end
   end

   assign samp_pos = pos_q[STAGES-1];
   assign samp_neg = neg_q[STAGES-1];
endmodule

// File: rtl/mwd_word_decoder.sv
module mwd_word_decoder
   import mwd_pkg::*;
#(
   parameter int OSR        = 8,
   parameter int TOL        = OSR / 4,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic                 clk,
   input  logic                 mr,
   input  logic                 samp_pos,
   input  logic                 samp_neg,
   output logic                 evt_ok,
   output logic                 evt_err,
   output logic                 evt_cmd,
   output logic [WORD_BITS-1:0] evt_data
);
   localparam int QTR     = OSR / 4;
   localparam int HALF    = OSR / 2;
   localparam int Q3      = 3 * OSR / 4;
   localparam int SYNCH   = 3 * OSR / 2;
   localparam int RUN_MAX = SYNCH + TOL;
   localparam int RUN_MIN = SYNCH - TOL;
   localparam int RW      = $clog2(RUN_MAX + 2);
   localparam int PW      = $clog2(SYNCH);
   localparam int CW      = $clog2(OSR);
   localparam int BW      = $clog2(FRAME_BITS + 1);

   localparam logic [RW-1:0] RUN_MAX_V = RW'(RUN_MAX);
   localparam logic [RW-1:0] RUN_MIN_V = RW'(RUN_MIN);
   localparam logic [PW-1:0] PH_CHK_V  = PW'(HALF);
   localparam logic [PW-1:0] PH_END_V  = PW'(SYNCH - 1);
   localparam logic [CW-1:0] C_QTR_V   = CW'(QTR);
   localparam logic [CW-1:0] C_Q3_V    = CW'(Q3);
   localparam logic [CW-1:0] C_END_V   = CW'(OSR - 1);
   localparam logic [BW-1:0] B_LAST_V  = BW'(FRAME_BITS);

   dec_state_t            state;
   logic [RW-1:0]         run;
   logic [PW-1:0]         ph;
   logic [CW-1:0]         cph;
   logic [BW-1:0]         bcnt;
   logic                  first_lvl;
   logic                  h1;
   logic [FRAME_BITS-1:0] shreg;
   logic                  lvl_ok;
   logic                  lvl_idle;
   logic                  par_good;

   assign lvl_ok   = samp_pos ^ samp_neg;
   assign lvl_idle = ~samp_pos & ~samp_neg;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_good = ^shreg;
      end else begin : g_even
         assign par_good = ~^shreg;
      end
   endgenerate

   always_ff @(posedge clk or posedge mr) begin
      if (mr) begin
         state     <= ST_HUNT;
         run       <= '0;
         ph        <= '0;
         cph       <= '0;
         bcnt      <= '0;
         first_lvl <= 1'b0;
         h1        <= 1'b0;
         shreg     <= '0;
         evt_ok    <= 1'b0;
         evt_err   <= 1'b0;
         evt_cmd   <= 1'b0;
         evt_data  <= '0;
      end else begin
         evt_ok  <= 1'b0;
         evt_err <= 1'b0;
         unique case (state)
            ST_HUNT: begin
               if (lvl_ok) begin
                  first_lvl <= samp_pos;
                  run       <= RW'(1);
                  state     <= ST_SYNC1;
               end
            end
            ST_SYNC1: begin
               if (!lvl_ok) begin
                  state <= ST_HUNT;
               end else if (samp_pos == first_lvl) begin
                  if (run == RUN_MAX_V) state <= ST_TAIL;
                  else                  run   <= run + 1'b1;
               end else if (run >= RUN_MIN_V) begin
                  ph    <= PW'(1);
                  state <= ST_SYNC2;
               end else begin
                  state <= ST_TAIL;
               end
            end
            ST_SYNC2: begin
               if (ph == PH_CHK_V && (!lvl_ok || samp_pos == first_lvl)) begin
                  evt_err <= 1'b1;
                  state   <= ST_TAIL;
               end else if (ph == PH_END_V) begin
                  cph   <= '0;
                  bcnt  <= '0;
                  state <= ST_BITS;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_BITS: begin
               if (cph == C_QTR_V) begin
                  if (bcnt == B_LAST_V) begin
                     state <= ST_TAIL;
                     if (lvl_idle) begin
                        evt_ok   <= par_good;
                        evt_err  <= ~par_good;
                        evt_cmd  <= first_lvl;
                        evt_data <= shreg[FRAME_BITS-1:1];
                     end else begin
                        evt_err <= 1'b1;
                     end
                  end else if (!lvl_ok) begin
                     evt_err <= 1'b1;
                     state   <= ST_TAIL;
                  end else begin
                     h1  <= samp_pos;
                     cph <= cph + 1'b1;
                  end
               end else if (cph == C_Q3_V) begin
                  if (!lvl_ok || samp_pos == h1) begin
                     evt_err <= 1'b1;
                     state   <= ST_TAIL;
                  end else begin
                     shreg <= {shreg[FRAME_BITS-2:0], h1};
                     cph   <= cph + 1'b1;
                  end
               end else if (cph == C_END_V) begin
                  cph  <= '0;
                  bcnt <= bcnt + 1'b1;
               end else begin
                  cph <= cph + 1'b1;
               end
            end
            ST_TAIL: begin
               if (lvl_idle) state <= ST_HUNT;
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   a_r1_ok_err_exclusive: assert property (@(posedge clk) disable iff (mr)
      !(evt_ok && evt_err));

   a_r5_bitcount_bound: assert property (@(posedge clk) disable iff (mr)
      (state == ST_BITS) |-> (bcnt <= B_LAST_V));

   a_r11_sync_run_bound: assert property (@(posedge clk) disable iff (mr)
      (state == ST_SYNC1) |-> (run <= RUN_MAX_V));
endmodule

// File: rtl/mwd_rx_status.sv
module mwd_rx_status
   import mwd_pkg::*;
(
   input  logic                 clk,
   input  logic                 mr,
   input  logic                 evt_ok,
   input  logic                 evt_err,
   input  logic                 evt_cmd,
   input  logic [WORD_BITS-1:0] evt_data,
   input  logic                 rd,
   input  logic                 err_clr,
   output logic [WORD_BITS-1:0] word,
   output logic                 rcv,
   output logic                 err,
   output logic                 cmd
);
   always_ff @(posedge clk or posedge mr) begin
      if (mr) begin
         word <= '0;
         rcv  <= 1'b0;
         err  <= 1'b0;
         cmd  <= 1'b0;
      end else begin
         if (evt_ok) begin
            word <= evt_data;
            cmd  <= evt_cmd;
            rcv  <= 1'b1;
         end else if (rd) begin
            rcv <= 1'b0;
         end
         if (evt_err)      err <= 1'b1;
         else if (err_clr) err <= 1'b0;
      end
   end

   a_r2_read_clears: assert property (@(posedge clk) disable iff (mr)
      (rd && !evt_ok) |=> !rcv);

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (mr)
      (err && !err_clr) |=> err);

   a_r3_rcv_needs_ok: assert property (@(posedge clk) disable iff (mr)
      $rose(rcv) |-> $past(evt_ok));

   a_r3_word_holds: assert property (@(posedge clk) disable iff (mr)
      !evt_ok |=> $stable(word));
endmodule

// File: rtl/mwd_dual_rx.sv
module mwd_dual_rx
   import mwd_pkg::*;
#(
   parameter int OSR         = 8,
   parameter int TOL         = OSR / 4,
   parameter int SYNC_STAGES = 2,
   parameter bit ODD_PARITY  = 1'b1
) (
   input  logic        clk,
   input  logic        mr,
   input  logic        bus_a_pos,
   input  logic        bus_a_neg,
   input  logic        bus_b_pos,
   input  logic        bus_b_neg,
   input  logic        rd_a,
   input  logic        rd_b,
   input  logic        err_clr,
   output logic [15:0] rx_word_a,
   output logic [15:0] rx_word_b,
   output logic        rcv_a,
   output logic        rcv_b,
   output logic        sync_cmd_a,
   output logic        sync_cmd_b,
   output logic        err_any,
   output logic [15:0] status
);
   localparam int NBUS = 2;

   generate
      if (OSR < 8 || (OSR % 4) != 0) begin : g_bad_osr
         $error("mwd_dual_rx: OSR must be a multiple of 4 and at least 8");
      end
      if (TOL < 1 || TOL >= OSR / 2) begin : g_bad_tol
         $error("mwd_dual_rx: TOL must lie between 1 and OSR/2-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mwd_dual_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NBUS-1:0]      pos_v;
   logic [NBUS-1:0]      neg_v;
   logic [NBUS-1:0]      rd_v;
   logic [NBUS-1:0]      rcv_v;
   logic [NBUS-1:0]      err_v;
   logic [NBUS-1:0]      cmd_v;
   logic [WORD_BITS-1:0] word_v [NBUS];

   assign pos_v = {bus_b_pos, bus_a_pos};
   assign neg_v = {bus_b_neg, bus_a_neg};
   assign rd_v  = {rd_b, rd_a};

   for (genvar gi = 0; gi < NBUS; gi++) begin : g_bus
      logic                 s_pos;
      logic                 s_neg;
      logic                 e_ok;
      logic                 e_err;
      logic                 e_cmd;
      logic [WORD_BITS-1:0] e_data;

      mwd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .mr       (mr),
         .line_pos (pos_v[gi]),
         .line_neg (neg_v[gi]),
         .samp_pos (s_pos),
         .samp_neg (s_neg)
      );

      mwd_word_decoder #(
         .OSR        (OSR),
         .TOL        (TOL),
         .ODD_PARITY (ODD_PARITY)
      ) u_dec (
         .clk      (clk),
         .mr       (mr),
         .samp_pos (s_pos),
         .samp_neg (s_neg),
         .evt_ok   (e_ok),
         .evt_err  (e_err),
         .evt_cmd  (e_cmd),
         .evt_data (e_data)
      );

      mwd_rx_status u_stat (
         .clk      (clk),
         .mr       (mr),
         .evt_ok   (e_ok),
         .evt_err  (e_err),
         .evt_cmd  (e_cmd),
         .evt_data (e_data),
         .rd       (rd_v[gi]),
         .err_clr  (err_clr),
         .word     (word_v[gi]),
         .rcv      (rcv_v[gi]),
         .err      (err_v[gi]),
         .cmd      (cmd_v[gi])
      );
   end

   assign rx_word_a  = word_v[0];
   assign rx_word_b  = word_v[1];
   assign rcv_a      = rcv_v[0];
   assign rcv_b      = rcv_v[1];
   assign sync_cmd_a = cmd_v[0];
   assign sync_cmd_b = cmd_v[1];
   assign err_any    = |err_v;

   always_comb begin
      status             = '0;
      status[STAT_RCV_A] = rcv_v[0];
      status[STAT_ERR_A] = err_v[0];
      status[STAT_RCV_B] = rcv_v[1];
      status[STAT_ERR_B] = err_v[1];
   end

   a_r7_err_any_follows: assert property (@(posedge clk) disable iff (mr)
      (status[STAT_ERR_A] || status[STAT_ERR_B]) |-> err_any);
endmodule

// File: tb/mwd_dual_rx_bench.sv
module mwd_dual_rx_bench;
   localparam int OSR  = 8;
   localparam int WLEN = 400;

   logic        clk = 1'b0;
   logic        mr = 1'b1;
   logic        a_pos = 1'b0, a_neg = 1'b0, b_pos = 1'b0, b_neg = 1'b0;
   logic        rd_a = 1'b0, rd_b = 1'b0, err_clr = 1'b0;
   logic [15:0] rx_word_a, rx_word_b, status;
   logic        rcv_a, rcv_b, sync_cmd_a, sync_cmd_b, err_any;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [1:0] wav_a [0:WLEN-1];
   logic [1:0] wav_b [0:WLEN-1];

   always #4 clk = ~clk;

   mwd_dual_rx u_mwd_dual_rx (
      .clk(clk), .mr(mr),
      .bus_a_pos(a_pos), .bus_a_neg(a_neg),
      .bus_b_pos(b_pos), .bus_b_neg(b_neg),
      .rd_a(rd_a), .rd_b(rd_b), .err_clr(err_clr),
      .rx_word_a(rx_word_a), .rx_word_b(rx_word_b),
      .rcv_a(rcv_a), .rcv_b(rcv_b),
      .sync_cmd_a(sync_cmd_a), .sync_cmd_b(sync_cmd_b),
      .err_any(err_any), .status(status)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic clear_waves();
      for (int i = 0; i < WLEN; i++) begin
         wav_a[i] = 2'd0;
         wav_b[i] = 2'd0;
      end
   endtask

   // codes: 0 idle, 1 high level, 2 low level
   task automatic build(input int bus, input logic [15:0] d, input bit cmd,
                        input bit bad_par, input int kill, input int nbits,
                        input int runlen);
      int i;
      logic v;
      logic [1:0] l1, l2;
      i = 0;
      for (int s = 0; s < runlen; s++) begin
         if (bus == 0) wav_a[i] = cmd ? 2'd1 : 2'd2; else wav_b[i] = cmd ? 2'd1 : 2'd2;
         i++;
      end
      for (int s = 0; s < 3 * OSR / 2; s++) begin
         if (bus == 0) wav_a[i] = cmd ? 2'd2 : 2'd1; else wav_b[i] = cmd ? 2'd2 : 2'd1;
         i++;
      end
      for (int b = 0; b < nbits; b++) begin
         if (b < 16)       v = d[15 - b];
         else if (b == 16) v = (~^d) ^ bad_par;
         else              v = 1'b0;
         l1 = v ? 2'd1 : 2'd2;
         l2 = v ? 2'd2 : 2'd1;
         if (b == kill) l2 = l1;
         for (int s = 0; s < OSR; s++) begin
            if (bus == 0) wav_a[i] = (s < OSR / 2) ? l1 : l2;
            else          wav_b[i] = (s < OSR / 2) ? l1 : l2;
            i++;
         end
      end
   endtask

   task automatic play();
      for (int k = 0; k < WLEN; k++) begin
         @(negedge clk);
         a_pos = (wav_a[k] == 2'd1);
         a_neg = (wav_a[k] == 2'd2);
         b_pos = (wav_b[k] == 2'd1);
         b_neg = (wav_b[k] == 2'd2);
      end
      @(negedge clk);
      a_pos = 1'b0; a_neg = 1'b0; b_pos = 1'b0; b_neg = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send(input int bus, input logic [15:0] d, input bit cmd,
                       input bit bad_par, input int kill, input int nbits,
                       input int runlen);
      clear_waves();
      build(bus, d, cmd, bad_par, kill, nbits, runlen);
      play();
   endtask

   task automatic pulse_rd(input int bus);
      @(negedge clk);
      if (bus == 0) rd_a = 1'b1; else rd_b = 1'b1;
      @(negedge clk);
      rd_a = 1'b0; rd_b = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d, last_a;
      clear_waves();
      repeat (5) @(negedge clk);
      // R10 reset state
      chk("R10 reset status", status, 0);
      chk("R10 reset words", {rx_word_a, rx_word_b}, 0);
      chk("R10 reset flags", {rcv_a, rcv_b, sync_cmd_a, sync_cmd_b, err_any}, 0);
      mr = 1'b0;
      repeat (3) @(negedge clk);

      // R1 / R2 / R7 sweep over patterns, sync types and buses
      for (int bus = 0; bus < 2; bus++) begin
         for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 40; p++) begin
               if (p < 16)       d = 16'h1 << p;
               else if (p < 32)  d = ~(16'h1 << (p - 16));
               else if (p == 32) d = 16'h0000;
               else if (p == 33) d = 16'hFFFF;
               else              d = 16'(p * 40503) ^ 16'h5A5A;
               send(bus, d, c[0], 1'b0, -1, 17, 3 * OSR / 2);
               chk("R1 word", bus == 0 ? rx_word_a : rx_word_b, d);
               chk("R1 rcv", bus == 0 ? rcv_a : rcv_b, 1);
               chk("R1 sync polarity", bus == 0 ? sync_cmd_a : sync_cmd_b, c);
               chk("R7 status map rcv", status, bus == 0 ? 32'h0080 : 32'h0800);
               chk("R7 no error", err_any, 0);
               pulse_rd(bus);
               chk("R2 read clears", bus == 0 ? rcv_a : rcv_b, 0);
            end
         end
      end

      // R3 missing mid-cell transition in every cell
      send(0, 16'h3C96, 1'b1, 1'b0, -1, 17, 12);
      pulse_rd(0);
      last_a = 16'h3C96;
      for (int k = 0; k < 17; k++) begin
         send(0, 16'hA5C3, 1'b0, 1'b0, k, 17, 12);
         chk("R3 error set", status, 32'h0400);
         chk("R3 no rcv", rcv_a, 0);
         chk("R3 word unchanged", rx_word_a, last_a);
         repeat (20) @(negedge clk);
         chk("R8 error sticky", err_any, 1);
         pulse_clr();
         chk("R8 error cleared", {err_any, status}, 0);
      end

      // R4 parity error on bus B, R7 map
      send(1, 16'h1234, 1'b1, 1'b1, -1, 17, 12);
      chk("R4 parity error", status, 32'h4000);
      chk("R4 rcv low", rcv_b, 0);
      chk("R7 err_any", err_any, 1);
      send(0, 16'h0F0F, 1'b1, 1'b1, -1, 17, 12);
      chk("R7 both errors", status, 32'h4400);
      pulse_clr();
      chk("R8 clear both", {err_any, status}, 0);

      // R5 short words
      send(0, 16'h7777, 1'b1, 1'b0, -1, 10, 12);
      chk("R5 short 10", {rcv_a, err_any}, 2'b01);
      pulse_clr();
      send(0, 16'h7777, 1'b1, 1'b0, -1, 16, 12);
      chk("R5 short 16", {rcv_a, err_any}, 2'b01);
      chk("R5 word unchanged", rx_word_a, last_a);
      pulse_clr();

      // R6 extra cells
      send(0, 16'h8001, 1'b0, 1'b0, -1, 18, 12);
      chk("R6 extra 1", {rcv_a, err_any}, 2'b01);
      pulse_clr();
      send(0, 16'h8001, 1'b0, 1'b0, -1, 19, 12);
      chk("R6 extra 2", {rcv_a, err_any}, 2'b01);
      pulse_clr();

      // R11 sync window
      send(0, 16'h4242, 1'b1, 1'b0, -1, 17, 9);
      chk("R11 short sync ignored", {rcv_a, err_any}, 0);
      send(0, 16'h4242, 1'b1, 1'b0, -1, 17, 15);
      chk("R11 long sync ignored", {rcv_a, err_any}, 0);
      send(0, 16'h2468, 1'b1, 1'b0, -1, 17, 10);
      chk("R11 min sync accepted", {rcv_a, rx_word_a}, {1'b1, 16'h2468});
      pulse_rd(0);
      send(0, 16'h1357, 1'b0, 1'b0, -1, 17, 14);
      chk("R11 max sync accepted", {rcv_a, rx_word_a}, {1'b1, 16'h1357});
      pulse_rd(0);

      // R9 simultaneous words on both buses
      clear_waves();
      build(0, 16'hBEEF, 1'b1, 1'b0, -1, 17, 12);
      build(1, 16'hC0DE, 1'b0, 1'b0, -1, 17, 12);
      play();
      chk("R9 bus A word", rx_word_a, 16'hBEEF);
      chk("R9 bus B word", rx_word_b, 16'hC0DE);
      chk("R9 sync flags", {sync_cmd_a, sync_cmd_b}, 2'b10);
      chk("R9 both rcv", status, 32'h0880);
      pulse_rd(0);
      chk("R2 read A only", {rcv_a, rcv_b}, 2'b01);

      // R10 master reset clears everything
      send(0, 16'h5555, 1'b1, 1'b1, -1, 17, 12);
      @(negedge clk);
      mr = 1'b1;
      @(negedge clk);
      chk("R10 mr clears", {status, rx_word_a, rx_word_b}, 0);
      chk("R10 mr flags", {sync_cmd_a, sync_cmd_b, err_any}, 0);
      mr = 1'b0;

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule